// File: doc/BRIEF.md
# DMA Logical-to-Physical Page Translator

This block sits on the path from DMA channels to system memory. A channel presents a 24-bit logical address, and the block returns a 29-bit physical address. The logical address is split into a 12-bit page index and a 12-bit byte offset. The index selects an 8-byte entry in a translation table held in system memory. The first 32-bit word of that entry gives the physical page frame, and the offset passes through unchanged.

Software loads three values through a small register port: the physical base of the table, the table size in bytes (the limit), and an invalidate strobe. Recent translations are kept in a 4-entry fully associative cache that is filled in round-robin order. A cache hit answers on the cycle after the request is accepted. A miss issues a single memory read. A lookup whose table byte offset is at or past the limit is answered with an error flag instead of a fetch, and the faulting logical address is latched for software to read.

Top module: `dma_page_xlate`

## Requirements
- R1: After reset, req_ready_o is 1 and rsp_valid_o and mem_req_o are 0. The base, limit, invalidate and fault registers all read 0.
- R2: The physical address is {entry word bits [28:12], logical address bits [11:0]}. Entry word bits [31:29] and [11:0] have no effect on the result.
- R3: On a cache miss the block makes exactly one memory read, at address base + index*8, where index is logical address bits [23:12]. mem_req_o and mem_addr_o stay unchanged until mem_gnt_i is seen.
- R4: On a cache hit, rsp_valid_o rises on the cycle right after acceptance, and no memory read is made.
- R5: The cache holds 4 translations. Fills go to slots 0,1,2,3,0,... in turn, whatever the hit pattern, so the fifth distinct page evicts the first one filled.
- R6: When index*8 >= limit, the response has rsp_err_o=1 and no memory read is made. The logical address is latched into the fault register, which reads at register address 3.
- R7: Any write to register address 2, whatever the data, discards every cached translation. Before such a write, a cached entry keeps returning its old frame even if memory has changed.
- R8: If the invalidate write lands while a fetch is outstanding, the fetched translation is still returned but is not cached.
- R9: While rsp_valid_o=1 and rsp_ready_i=0, the response holds steady and no new request is accepted (req_ready_o=0).
- R10: The register map is: address 0 = table base (bits [28:0]), address 1 = limit (32 bits), address 2 = invalidate (reads 0), address 3 = fault address (read-only).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Ready to accept a request |
| req_laddr_i | input | 24 | Logical address |
| rsp_valid_o | output | 1 | Response valid |
| rsp_ready_i | input | 1 | Response consumed |
| rsp_paddr_o | output | 29 | Physical address |
| rsp_err_o | output | 1 | Address error (index beyond limit) |
| mem_req_o | output | 1 | Table read request |
| mem_gnt_i | input | 1 | Table read granted |
| mem_addr_o | output | 29 | Table entry address |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data (entry word) |

## Verification
The bench goes after replacement order: it walks past the four slots so that a wrong victim pointer, for example LRU or one that skips a slot on hits, shows up as an unexpected fetch or a missing one. It changes table memory without invalidating, to show that a cache which refetches is not caching, and then invalidates both while idle and in the middle of a stalled fetch. A design that caches the in-flight result after a flush would miss no fetch on the next lookup. The limit is probed at index 15 and 16 with a 128-byte limit, which catches an off-by-one compare. Backpressure on the response catches a design that drops or changes its answer, or accepts a new request too early.

// File: rtl/dpx_pkg.sv
package dpx_pkg;
  localparam int unsigned ENTRY_SHIFT = 3;  // 8 bytes per table entry

  localparam logic [1:0] REG_BASE  = 2'd0;
  localparam logic [1:0] REG_LIMIT = 2'd1;
  localparam logic [1:0] REG_INVAL = 2'd2;
  localparam logic [1:0] REG_FAULT = 2'd3;

  typedef enum logic [1:0] {
    S_IDLE,
    S_FETCH,
    S_WAIT,
    S_RESP
  } xl_state_e;
endpackage

// File: rtl/dpx_regs.sv
module dpx_regs
  import dpx_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned PADDR_W = 29,
  parameter int unsigned LADDR_W = 24
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [1:0]         addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  input  logic               fault_set_i,
  input  logic [LADDR_W-1:0] fault_laddr_i,
  output logic [PADDR_W-1:0] base_o,
  output logic [DATA_W-1:0]  limit_o,
  output logic [LADDR_W-1:0] fault_o,
  output logic               flush_o
);
  logic [PADDR_W-1:0] base_q;
  logic [DATA_W-1:0]  limit_q;
  logic [LADDR_W-1:0] fault_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q  <= '0;
      limit_q <= '0;
      fault_q <= '0;
    end else begin
      if (we_i && addr_i == REG_BASE)  base_q  <= wdata_i[PADDR_W-1:0];
      if (we_i && addr_i == REG_LIMIT) limit_q <= wdata_i;
      if (fault_set_i)                 fault_q <= fault_laddr_i;
    end
  end

  assign flush_o = we_i && (addr_i == REG_INVAL);

  always_comb begin
    unique case (addr_i)
      REG_BASE:  rdata_o = DATA_W'(base_q);
      REG_LIMIT: rdata_o = limit_q;
      REG_FAULT: rdata_o = DATA_W'(fault_q);
      default:   rdata_o = '0;
    endcase
  end

  assign base_o  = base_q;
  assign limit_o = limit_q;
  assign fault_o = fault_q;

  // R6
  fault_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_set_i |=> fault_q == $past(fault_laddr_i));
endmodule

// File: rtl/dpx_cache.sv
module dpx_cache #(
  parameter int unsigned ENTRIES = 4,
  parameter int unsigned TAG_W   = 12,
  parameter int unsigned DATA_W  = 17
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic [TAG_W-1:0]  lookup_tag_i,
  output logic              hit_o,
  output logic [DATA_W-1:0] hit_data_o,
  input  logic              fill_i,
  input  logic [TAG_W-1:0]  fill_tag_i,
  input  logic [DATA_W-1:0] fill_data_i
);
  localparam int unsigned PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] valid_q;
  logic [TAG_W-1:0]   tag_q  [ENTRIES];
  logic [DATA_W-1:0]  data_q [ENTRIES];
  logic [PTR_W-1:0]   victim_q;
  logic [ENTRIES-1:0] match;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_way
    assign match[g] = valid_q[g] && (tag_q[g] == lookup_tag_i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[g] <= 1'b0;
        tag_q[g]   <= '0;
        data_q[g]  <= '0;
      end else if (flush_i) begin
        valid_q[g] <= 1'b0;
      end else if (fill_i && victim_q == PTR_W'(g)) begin
        valid_q[g] <= 1'b1;
        tag_q[g]   <= fill_tag_i;
        data_q[g]  <= fill_data_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) victim_q <= '0;
    else if (fill_i && !flush_i)
      victim_q <= (victim_q == PTR_W'(ENTRIES - 1)) ? '0 : victim_q + 1'b1;
  end

  always_comb begin
    hit_data_o = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (match[i]) hit_data_o = data_q[i];
  end
  assign hit_o = |match;

  // R5
  single_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(match));

  // R7
  flush_empties_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !hit_o);
endmodule

// File: rtl/dma_page_xlate.sv
module dma_page_xlate
  import dpx_pkg::*;
#(
  parameter int unsigned LADDR_W       = 24,
  parameter int unsigned PADDR_W       = 29,
  parameter int unsigned PAGE_BITS     = 12,
  parameter int unsigned DATA_W        = 32,
  parameter int unsigned CACHE_ENTRIES = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_we_i,
  input  logic [1:0]         reg_addr_i,
  input  logic [DATA_W-1:0]  reg_wdata_i,
  output logic [DATA_W-1:0]  reg_rdata_o,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic [LADDR_W-1:0] req_laddr_i,
  output logic               rsp_valid_o,
  input  logic               rsp_ready_i,
  output logic [PADDR_W-1:0] rsp_paddr_o,
  output logic               rsp_err_o,
  output logic               mem_req_o,
  input  logic               mem_gnt_i,
  output logic [PADDR_W-1:0] mem_addr_o,
  input  logic               mem_rvalid_i,
  input  logic [DATA_W-1:0]  mem_rdata_i
);
  localparam int unsigned IDX_W   = LADDR_W - PAGE_BITS;
  localparam int unsigned FRAME_W = PADDR_W - PAGE_BITS;

  xl_state_e state_q;
  logic [LADDR_W-1:0] laddr_q;
  logic [PADDR_W-1:0] paddr_q;
  logic               err_q, drop_q;

  logic [PADDR_W-1:0] base;
  logic [DATA_W-1:0]  limit;
  logic [LADDR_W-1:0] fault;
  logic               flush;
  logic               lk_hit;
  logic [FRAME_W-1:0] lk_frame;
  logic               accept, oob, fill;
  logic [IDX_W-1:0]   req_idx, cur_idx;

  assign req_idx = req_laddr_i[LADDR_W-1:PAGE_BITS];
  assign cur_idx = laddr_q[LADDR_W-1:PAGE_BITS];
  assign accept  = req_valid_i && req_ready_o;
  assign oob     = DATA_W'({req_idx, {ENTRY_SHIFT{1'b0}}}) >= limit;
  assign fill    = (state_q == S_WAIT) && mem_rvalid_i && !drop_q && !flush;

  dpx_regs #(.DATA_W(DATA_W), .PADDR_W(PADDR_W), .LADDR_W(LADDR_W)) i_regs (
    .clk_i, .rst_ni,
    .we_i         (reg_we_i),
    .addr_i       (reg_addr_i),
    .wdata_i      (reg_wdata_i),
    .rdata_o      (reg_rdata_o),
    .fault_set_i  (accept && oob),
    .fault_laddr_i(req_laddr_i),
    .base_o       (base),
    .limit_o      (limit),
    .fault_o      (fault),
    .flush_o      (flush)
  );

  dpx_cache #(.ENTRIES(CACHE_ENTRIES), .TAG_W(IDX_W), .DATA_W(FRAME_W)) i_cache (
    .clk_i, .rst_ni,
    .flush_i     (flush),
    .lookup_tag_i(req_idx),
    .hit_o       (lk_hit),
    .hit_data_o  (lk_frame),
    .fill_i      (fill),
    .fill_tag_i  (cur_idx),
    .fill_data_i (mem_rdata_i[PADDR_W-1:PAGE_BITS])
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      laddr_q <= '0;
      paddr_q <= '0;
      err_q   <= 1'b0;
      drop_q  <= 1'b0;
    end else begin
      unique case (state_q)
        S_IDLE: if (accept) begin
          laddr_q <= req_laddr_i;
          drop_q  <= 1'b0;
          if (oob) begin
            err_q   <= 1'b1;
            paddr_q <= '0;
            state_q <= S_RESP;
          end else if (lk_hit) begin
            err_q   <= 1'b0;
            paddr_q <= {lk_frame, req_laddr_i[PAGE_BITS-1:0]};
            state_q <= S_RESP;
          end else begin
            err_q   <= 1'b0;
            state_q <= S_FETCH;
          end
        end
        S_FETCH: begin
          if (flush)     drop_q  <= 1'b1;
          if (mem_gnt_i) state_q <= S_WAIT;
        end
        S_WAIT: begin
          if (flush) drop_q <= 1'b1;
          if (mem_rvalid_i) begin
            paddr_q <= {mem_rdata_i[PADDR_W-1:PAGE_BITS], laddr_q[PAGE_BITS-1:0]};
            state_q <= S_RESP;
          end
        end
        S_RESP: if (rsp_ready_i) state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign req_ready_o = (state_q == S_IDLE);
  assign rsp_valid_o = (state_q == S_RESP);
  assign rsp_paddr_o = paddr_q;
  assign rsp_err_o   = err_q;
  assign mem_req_o   = (state_q == S_FETCH);
  assign mem_addr_o  = base + PADDR_W'({cur_idx, {ENTRY_SHIFT{1'b0}}});

  // R3
  mem_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_gnt_i |=> mem_req_o && $stable(mem_addr_o));

  // R9
  rsp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_ready_i |=> rsp_valid_o && $stable(rsp_paddr_o) && $stable(rsp_err_o));

  // R4
  hit_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && lk_hit && !oob |=> rsp_valid_o && !rsp_err_o);

  // R6
  err_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_err_o |-> fault == laddr_q);

  // R9
  busy_no_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> !req_ready_o);
endmodule

// File: tb/test_dma_page_xlate.sv
module test_dma_page_xlate;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [28:0] BASE = 29'h0100000;

  // bit 24: expected hit, bits 23:0: logical address
  localparam logic [24:0] VEC [11] = '{
    25'h0_000123, 25'h1_000456, 25'h0_001010, 25'h0_002000,
    25'h0_003FFF, 25'h1_000FFF, 25'h0_004000, 25'h0_000001,
    25'h1_002ABC, 25'h0_001000, 25'h0_FFF777
  };

  logic clk = 0, rst_n = 0;
  logic reg_we = 0;
  logic [1:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic req_valid = 0, req_ready;
  logic [23:0] req_laddr = 0;
  logic rsp_valid, rsp_ready = 1, rsp_err;
  logic [28:0] rsp_paddr;
  logic mem_req, mem_gnt, mem_rvalid = 0;
  logic [28:0] mem_addr, last_addr = 0;
  logic [31:0] mem_rdata = 0;
  logic gnt_en = 1;
  int mem_gen = 0, fetch_cnt = 0;
  int errors = 0, checks = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dma_page_xlate i_dma_page_xlate (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_laddr_i(req_laddr),
    .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready), .rsp_paddr_o(rsp_paddr), .rsp_err_o(rsp_err),
    .mem_req_o(mem_req), .mem_gnt_i(mem_gnt), .mem_addr_o(mem_addr),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata)
  );

  function automatic logic [16:0] frame_of(int idx, int gen);
    return 17'(idx * 9 + gen * 4097 + 3);
  endfunction

  // table memory: junk in bits 31:29 and 11:0 of each entry word
  assign mem_gnt = mem_req && gnt_en;
  always @(posedge clk) begin
    mem_rvalid <= mem_req && mem_gnt;
    if (mem_req && mem_gnt) begin
      fetch_cnt <= fetch_cnt + 1;
      last_addr <= mem_addr;
      mem_rdata <= {3'b101, frame_of(int'((mem_addr - BASE) >> 3), mem_gen), 12'hFA5};
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic xlate(input logic [23:0] la, input bit exp_err, input bit exp_hit,
                       input int gen, input int hold, input string tag);
    int f0, lat;
    logic [28:0] exp_pa, held;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    f0 = fetch_cnt;
    if (hold > 0) rsp_ready = 0;
    req_valid = 1; req_laddr = la;
    @(negedge clk);
    req_valid = 0;
    lat = 1;
    while (!rsp_valid) begin @(negedge clk); lat++; end
    exp_pa = {frame_of(int'(la[23:12]), gen), la[11:0]};
    check(rsp_err == exp_err, {tag, " err"}, 32'(rsp_err), 32'(exp_err));
    if (!exp_err) check(rsp_paddr == exp_pa, {tag, " paddr"}, 32'(rsp_paddr), 32'(exp_pa));
    check(fetch_cnt - f0 == ((exp_err || exp_hit) ? 0 : 1), {tag, " fetches"},
          32'(fetch_cnt - f0), 32'((exp_err || exp_hit) ? 0 : 1));
    if (!exp_err && !exp_hit)
      check(last_addr == BASE + 29'({la[23:12], 3'b000}), {tag, " R3 fetch addr"},
            32'(last_addr), 32'(BASE + 29'({la[23:12], 3'b000})));
    if (exp_hit) check(lat == 1, {tag, " R4 hit latency"}, 32'(lat), 32'd1);
    if (hold > 0) begin
      held = rsp_paddr;
      repeat (hold) @(negedge clk);
      check(rsp_valid && !req_ready && rsp_paddr == held, "R9 hold under backpressure",
            32'(rsp_paddr), 32'(held));
      rsp_ready = 1;
      @(negedge clk);
      check(!rsp_valid && req_ready, "R9 release", 32'(rsp_valid), 32'd0);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    check(req_ready && !rsp_valid && !mem_req, "R1 idle outputs",
          {29'd0, req_ready, rsp_valid, mem_req}, 32'h4);
    for (int a = 0; a < 4; a++) begin
      reg_read(2'(a), d);
      check(d == 0, "R1 register reset", d, 0);
    end
    // R6: limit 0 after reset, every lookup faults
    xlate(24'h000123, 1, 0, 0, 0, "R6 zero limit");
    reg_read(2'd3, d);
    check(d == 32'h000123, "R6 fault register", d, 32'h000123);
    // R10
    reg_write(2'd0, 32'hE010_0000);
    reg_write(2'd1, 32'h0000_8000);
    reg_read(2'd0, d); check(d == 32'(BASE), "R10 base readback", d, 32'(BASE));
    reg_read(2'd1, d); check(d == 32'h8000, "R10 limit readback", d, 32'h8000);
    reg_read(2'd2, d); check(d == 0, "R10 invalidate reads 0", d, 0);
    // R2 R3 R4 R5 vector walk: fills go 0,1,2,3,0,... slots
    for (int i = 0; i < 11; i++)
      xlate(VEC[i][23:0], 0, VEC[i][24], 0, 0, $sformatf("R2/R5 vec%0d", i));
    // R7: memory changes, cached page 0 still stale until invalidate
    mem_gen = 1;
    xlate(24'h000777, 0, 1, 0, 0, "R7 stale hit");
    reg_write(2'd2, 32'h1234_5678);
    xlate(24'h000777, 0, 0, 1, 0, "R7 after invalidate");
    // R9
    xlate(24'h000777, 0, 1, 1, 3, "R9 backpressure");
    // R8: invalidate while fetch stalled
    gnt_en = 0;
    fork
      xlate(24'h005000, 0, 0, 1, 0, "R8 in-flight");
      begin
        repeat (3) @(negedge clk);
        reg_write(2'd2, 32'h0);
        gnt_en = 1;
      end
    join
    xlate(24'h005000, 0, 0, 1, 0, "R8 not cached");
    // R6 boundary: limit 128 bytes = 16 entries
    reg_write(2'd1, 32'h80);
    xlate(24'h00F123, 0, 0, 1, 0, "R6 last in range");
    xlate(24'h010456, 1, 0, 1, 0, "R6 first out of range");
    reg_read(2'd3, d);
    check(d == 32'h010456, "R6 fault latched", d, 32'h010456);
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule